// File: doc/BRIEF.md
# Translation Cache with Global-Aware Flush

This block holds a handful of completed page translations in a fully associative array placed in front of a table walker. Each lookup presents a logical address, a supervisor flag and a write flag. One cycle later the block answers with hit or miss, the physical address, the two-bit cache mode, the two user attribute bits and a 32-bit probe status word. On a miss the walker resolves the translation and hands the resulting page descriptor back through the fill port. A new entry takes slots in round-robin order. A fill for a page that is already cached rewrites that slot in place.

A 16-bit control input sets the behaviour of every lookup while it runs. Bit 15 turns translation on. When it is clear, every lookup reports a transparent hit with the address unchanged. Bit 14 selects 8K pages when set and 4K pages when clear, so address bit 12 belongs either to the offset or to the tag. Four flush commands remove entries: all entries, all non-global entries, every entry for one page, or the non-global entries for one page. Entries whose global bit is set survive both non-global kinds.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is low. With translation enabled, the first lookup misses.
- R2: While control bit 15 is 0, a lookup returns hit, a physical address equal to the logical address, cache mode 00 and attributes 00. Its status word is the logical address bits 31:12 with bits 1 and 0 set and bits 11:2 zero.
- R3: Control bit 14 set to 0 selects 4K pages: address bits 31:12 form the tag and bits 11:0 pass to the physical address. Set to 1 it selects 8K pages: bits 31:13 form the tag and bits 12:0 pass through. The status word's bit 12 is then undefined.
- R4: Each entry records the supervisor flag it was filled with. A lookup whose flag differs misses.
- R5: A write lookup that matches an entry whose modified bit is clear reports a miss. A read of that entry hits, and a write hits once the entry is modified.
- R6: On a hit the cache mode (00 write-through, 01 copy-back, 10 non-cacheable serialized, 11 non-cacheable) and the user attribute bits are returned unchanged from the entry. The physical address is the entry's page joined to the lookup offset.
- R7: On a hit the status word holds the physical page in bits 31:12, 0 in bit 11, global in bit 10, user attributes in bits 9:8, supervisor-protect in bit 7, cache mode in bits 6:5, modified in bit 4, 0 in bit 3, write-protect in bit 2, 0 in bit 1 and 1 in bit 0. On a miss every response field is zero.
- R8: Flush-all (kind 00) invalidates every entry in one cycle. A lookup presented in the same cycle as any flush sees the entries as they were before it.
- R9: Flush-non-global (kind 01) invalidates every entry whose global bit is clear and leaves global entries valid.
- R10: Flush-by-page (kind 10) invalidates every entry for the page of `flush_addr` in either space, global or not. Flush-by-page-non-global (kind 11) spares a global entry for that page.
- R11: A fill for a page that is not cached writes the slot under a round-robin pointer and advances the pointer. With all slots used, the oldest allocation is replaced.
- R12: A fill whose page and supervisor flag match a cached entry rewrites that entry and does not advance the pointer.
- R13: The fill descriptor uses the status layout, with bits 1:0 as the type. A descriptor whose bit 0 is 0 (invalid 00 or indirect 10) is ignored.
- R14: `rsp_valid` is high exactly in the cycle after a cycle with `lk_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_ctrl | input | 16 | Bit 15 enable, bit 14 page size (1 = 8K) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Logical address of the lookup |
| lk_super | input | 1 | Lookup is a supervisor access |
| lk_write | input | 1 | Lookup is a write |
| fill_valid | input | 1 | Fill request from the walker |
| fill_addr | input | 32 | Logical address of the filled page |
| fill_super | input | 1 | Space of the filled page |
| fill_desc | input | 32 | Page descriptor for the fill |
| flush_valid | input | 1 | Flush request |
| flush_kind | input | 2 | 00 all, 01 non-global, 10 page, 11 page non-global |
| flush_addr | input | 32 | Address selecting the page for page flushes |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Physical address |
| rsp_cmode | output | 2 | Cache mode |
| rsp_upa | output | 2 | User attribute bits |
| rsp_status | output | 32 | Probe status word |

## Verification
The assertions check the properties that hold in every cycle. A response always follows a lookup by one cycle. A disabled lookup always passes its address through unchanged. A miss always returns zeros, and a hit's status word always agrees with its cache mode and attribute outputs. A write hit always carries the modified bit, and a lookup issued just after a flush-all always misses. The tag width under each page size, the separation of supervisor and user spaces, the survival of global entries through each flush kind, the round-robin victim order and the in-place refill all depend on the history of fills. Only the bench's scenarios can show them.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned PAGE_LSB = 12;
    localparam int unsigned VPN_W    = ADDR_W - PAGE_LSB;

    localparam int unsigned CTL_ENABLE = 15;
    localparam int unsigned CTL_BIG    = 14;

    typedef enum logic [1:0] {
        FL_ALL            = 2'b00,
        FL_NONGLOBAL      = 2'b01,
        FL_PAGE           = 2'b10,
        FL_PAGE_NONGLOBAL = 2'b11
    } flush_kind_e;

    typedef struct packed {
        logic             valid;
        logic             sup;
        logic [VPN_W-1:0] vpn;
        logic [VPN_W-1:0] ppn;
        logic             glob;
        logic [1:0]       upa;
        logic             sprot;
        logic [1:0]       cmode;
        logic             modif;
        logic             wprot;
    } entry_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] paddr;
        logic [1:0]        cmode;
        logic [1:0]        upa;
        logic [ADDR_W-1:0] status;
    } rsp_t;

    function automatic entry_t desc_to_entry(logic [ADDR_W-1:0] desc,
                                             logic [ADDR_W-1:0] vaddr,
                                             logic              sup);
        entry_t e;
        e.valid = 1'b1;
        e.sup   = sup;
        e.vpn   = vaddr[ADDR_W-1:PAGE_LSB];
        e.ppn   = desc[ADDR_W-1:PAGE_LSB];
        e.glob  = desc[10];
        e.upa   = desc[9:8];
        e.sprot = desc[7];
        e.cmode = desc[6:5];
        e.modif = desc[4];
        e.wprot = desc[2];
        return e;
    endfunction

    function automatic logic [ADDR_W-1:0] entry_status(entry_t e);
        return {e.ppn, 1'b0, e.glob, e.upa, e.sprot, e.cmode,
                e.modif, 1'b0, e.wprot, 1'b0, 1'b1};
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = 4
) (
    input  entry_t [ENTRIES-1:0] ents,
    input  logic   [VPN_W-1:0]   key_vpn,
    input  logic                 key_sup,
    input  logic                 use_sup,
    input  logic                 big_page,
    output logic   [ENTRIES-1:0] hits
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic hi_eq;
        logic b12_eq;
        logic sp_eq;
        assign hi_eq  = ents[i].vpn[VPN_W-1:1] == key_vpn[VPN_W-1:1];
        assign b12_eq = big_page || (ents[i].vpn[0] == key_vpn[0]);
        assign sp_eq  = !use_sup || (ents[i].sup == key_sup);
        assign hits[i] = ents[i].valid && hi_eq && b12_eq && sp_eq;
    end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int unsigned ENTRIES = 4,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance) begin
            if (ptr == IDX_W'(ENTRIES - 1)) ptr <= '0;
            else                            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/xlat_flush_mask.sv
module xlat_flush_mask
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = 4
) (
    input  logic               flush_valid,
    input  logic [1:0]         flush_kind,
    input  logic [ENTRIES-1:0] page_hits,
    input  logic [ENTRIES-1:0] globals,
    output logic [ENTRIES-1:0] kill
);

    always_comb begin
        kill = '0;
        if (flush_valid) begin
            unique case (flush_kind_e'(flush_kind))
                FL_ALL:            kill = '1;
                FL_NONGLOBAL:      kill = ~globals;
                FL_PAGE:           kill = page_hits;
                FL_PAGE_NONGLOBAL: kill = page_hits & ~globals;
                default:           kill = '0;
            endcase
        end
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = 4,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] xlat_ctrl,
    input  logic        lk_valid,
    input  logic [31:0] lk_addr,
    input  logic        lk_super,
    input  logic        lk_write,
    input  logic        fill_valid,
    input  logic [31:0] fill_addr,
    input  logic        fill_super,
    input  logic [31:0] fill_desc,
    input  logic        flush_valid,
    input  logic [1:0]  flush_kind,
    input  logic [31:0] flush_addr,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic [31:0] rsp_paddr,
    output logic [1:0]  rsp_cmode,
    output logic [1:0]  rsp_upa,
    output logic [31:0] rsp_status
);

    entry_t [ENTRIES-1:0] ent_q;
    rsp_t                 rsp_q;
    rsp_t                 rsp_d;

    logic en;
    logic big;
    assign en  = xlat_ctrl[CTL_ENABLE];
    assign big = xlat_ctrl[CTL_BIG];

    logic unused_bits;
    assign unused_bits = ^{xlat_ctrl[13:0], fill_addr[PAGE_LSB-1:0],
                           flush_addr[PAGE_LSB-1:0], fill_desc[11],
                           fill_desc[3], fill_desc[1]};

    logic [ENTRIES-1:0] globals;
    for (genvar i = 0; i < ENTRIES; i++) begin : g_glob
        assign globals[i] = ent_q[i].glob;
    end

    // lookup path
    logic [ENTRIES-1:0] lk_hits;
    xlat_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .ents     (ent_q),
        .key_vpn  (lk_addr[ADDR_W-1:PAGE_LSB]),
        .key_sup  (lk_super),
        .use_sup  (1'b1),
        .big_page (big),
        .hits     (lk_hits)
    );

    entry_t sel;
    always_comb begin
        sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hits[i]) sel = ent_q[i];
        end
    end

    logic tag_hit;
    logic use_hit;
    assign tag_hit = |lk_hits;
    assign use_hit = tag_hit && !(lk_write && !sel.modif);

    always_comb begin
        rsp_d = '0;
        if (!en) begin
            rsp_d.hit    = 1'b1;
            rsp_d.paddr  = lk_addr;
            rsp_d.status = {lk_addr[ADDR_W-1:PAGE_LSB], 10'b0, 2'b11};
        end else if (use_hit) begin
            rsp_d.hit    = 1'b1;
            rsp_d.paddr  = big ? {sel.ppn[VPN_W-1:1], lk_addr[PAGE_LSB:0]}
                               : {sel.ppn, lk_addr[PAGE_LSB-1:0]};
            rsp_d.cmode  = sel.cmode;
            rsp_d.upa    = sel.upa;
            rsp_d.status = entry_status(sel);
        end
    end

    // flush path
    logic [ENTRIES-1:0] fl_hits;
    logic [ENTRIES-1:0] kill;
    xlat_match #(.ENTRIES(ENTRIES)) u_fl_match (
        .ents     (ent_q),
        .key_vpn  (flush_addr[ADDR_W-1:PAGE_LSB]),
        .key_sup  (1'b0),
        .use_sup  (1'b0),
        .big_page (big),
        .hits     (fl_hits)
    );

    xlat_flush_mask #(.ENTRIES(ENTRIES)) u_flush (
        .flush_valid (flush_valid),
        .flush_kind  (flush_kind),
        .page_hits   (fl_hits),
        .globals     (globals),
        .kill        (kill)
    );

    // fill path
    logic [ENTRIES-1:0] fi_hits;
    xlat_match #(.ENTRIES(ENTRIES)) u_fi_match (
        .ents     (ent_q),
        .key_vpn  (fill_addr[ADDR_W-1:PAGE_LSB]),
        .key_sup  (fill_super),
        .use_sup  (1'b1),
        .big_page (big),
        .hits     (fi_hits)
    );

    logic             fill_ok;
    logic             fill_dup;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] tgt;

    assign fill_ok  = fill_valid && fill_desc[0];
    assign fill_dup = |fi_hits;

    always_comb begin
        dup_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fi_hits[i]) dup_idx = IDX_W'(i);
        end
    end

    assign tgt = fill_dup ? dup_idx : rr_ptr;

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk     (clk),
        .rst     (rst),
        .advance (fill_ok && !fill_dup),
        .ptr     (rr_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q     <= '0;
            rsp_q     <= '0;
            rsp_valid <= 1'b0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (kill[i]) ent_q[i].valid <= 1'b0;
            end
            if (fill_ok) ent_q[tgt] <= desc_to_entry(fill_desc, fill_addr, fill_super);
            rsp_valid <= lk_valid;
            rsp_q     <= lk_valid ? rsp_d : '0;
        end
    end

    assign rsp_hit    = rsp_q.hit;
    assign rsp_paddr  = rsp_q.paddr;
    assign rsp_cmode  = rsp_q.cmode;
    assign rsp_upa    = rsp_q.upa;
    assign rsp_status = rsp_q.status;

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] xlat_ctrl,
    input logic        lk_valid,
    input logic [31:0] lk_addr,
    input logic        lk_write,
    input logic        fill_valid,
    input logic        flush_valid,
    input logic [1:0]  flush_kind,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [31:0] rsp_paddr,
    input logic [1:0]  rsp_cmode,
    input logic [1:0]  rsp_upa,
    input logic [31:0] rsp_status
);

    logic fa1;
    logic fa2;
    always_ff @(posedge clk) begin
        if (rst) begin
            fa1 <= 1'b0;
            fa2 <= 1'b0;
        end else begin
            fa1 <= flush_valid && (flush_kind == 2'b00) && !fill_valid;
            fa2 <= fa1 && !fill_valid && lk_valid && xlat_ctrl[15];
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid);

    a_r14_rsp_follows_lookup: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    a_r14_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
        lk_valid && !xlat_ctrl[15] |=> rsp_hit && rsp_paddr == $past(lk_addr));

    a_r7_miss_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |-> rsp_status == 32'h0 && rsp_paddr == 32'h0
                                  && rsp_cmode == 2'b00 && rsp_upa == 2'b00);

    a_r7_status_agrees: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_hit |-> rsp_status[0] && rsp_status[6:5] == rsp_cmode
                                 && rsp_status[9:8] == rsp_upa);

    a_r5_write_needs_modified: assert property (@(posedge clk) disable iff (rst)
        lk_valid && lk_write && xlat_ctrl[15] |=> !rsp_hit || rsp_status[4]);

    a_r8_flush_all_empties: assert property (@(posedge clk) disable iff (rst)
        fa2 |-> rsp_valid && !rsp_hit);

endmodule

bind xlat_cache xlat_cache_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .xlat_ctrl   (xlat_ctrl),
    .lk_valid    (lk_valid),
    .lk_addr     (lk_addr),
    .lk_write    (lk_write),
    .fill_valid  (fill_valid),
    .flush_valid (flush_valid),
    .flush_kind  (flush_kind),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_paddr   (rsp_paddr),
    .rsp_cmode   (rsp_cmode),
    .rsp_upa     (rsp_upa),
    .rsp_status  (rsp_status)
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] xlat_ctrl;
    logic        lk_valid, lk_super, lk_write;
    logic [31:0] lk_addr;
    logic        fill_valid, fill_super;
    logic [31:0] fill_addr, fill_desc;
    logic        flush_valid;
    logic [1:0]  flush_kind;
    logic [31:0] flush_addr;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_paddr, rsp_status;
    logic [1:0]  rsp_cmode, rsp_upa;

    always #10 clk = ~clk;

    xlat_cache u_xlat_cache (
        .clk(clk), .rst(rst), .xlat_ctrl(xlat_ctrl),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_super(lk_super), .lk_write(lk_write),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_super(fill_super),
        .fill_desc(fill_desc), .flush_valid(flush_valid), .flush_kind(flush_kind),
        .flush_addr(flush_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_paddr(rsp_paddr), .rsp_cmode(rsp_cmode), .rsp_upa(rsp_upa),
        .rsp_status(rsp_status)
    );

    typedef struct {
        logic        hit;
        logic [31:0] pa;
        logic [1:0]  cm;
        logic [1:0]  upa;
        logic [31:0] st;
        logic [31:0] mask;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 0;

    localparam logic [15:0] CTL_4K  = 16'h8000;
    localparam logic [15:0] CTL_8K  = 16'hC000;
    localparam logic [15:0] CTL_OFF = 16'h0000;

    function automatic logic [31:0] mkd(logic [19:0] ppn, logic g, logic [1:0] upa,
                                        logic s, logic [1:0] cm, logic m, logic w,
                                        logic [1:0] ty);
        return {ppn, 1'b0, g, upa, s, cm, m, 1'b0, w, ty};
    endfunction

    // monitor: compares each response against the head of the queue
    always @(negedge clk) begin
        if (!rst && !finished && rsp_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R14: response with no lookup pending, actual hit=%0b expected none", rsp_hit);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_hit !== e.hit || rsp_paddr !== e.pa || rsp_cmode !== e.cm ||
                    rsp_upa !== e.upa || (rsp_status & e.mask) !== (e.st & e.mask)) begin
                    n_fails++;
                    $display("FAIL %s: actual hit=%0b pa=%h cm=%b upa=%b st=%h expected hit=%0b pa=%h cm=%b upa=%b st=%h",
                             e.req, rsp_hit, rsp_paddr, rsp_cmode, rsp_upa, rsp_status & e.mask,
                             e.hit, e.pa, e.cm, e.upa, e.st & e.mask);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
        lk_valid = 0; fill_valid = 0; flush_valid = 0; lk_write = 0;
    endtask

    task automatic put(exp_t e, logic [31:0] a, logic s, logic w);
        lk_valid = 1; lk_addr = a; lk_super = s; lk_write = w;
        exp_q.push_back(e);
    endtask

    task automatic lk_hit(logic [31:0] a, logic s, logic w, logic [31:0] d,
                          logic big, string req);
        exp_t e;
        e.hit  = 1;
        e.pa   = big ? {d[31:13], a[12:0]} : {d[31:12], a[11:0]};
        e.cm   = d[6:5];
        e.upa  = d[9:8];
        e.st   = {d[31:12], 1'b0, d[10:4], 1'b0, d[2], 2'b01};
        e.mask = big ? 32'hFFFF_EFFF : 32'hFFFF_FFFF;
        e.req  = req;
        put(e, a, s, w);
    endtask

    task automatic lk_miss(logic [31:0] a, logic s, logic w, string req);
        exp_t e;
        e.hit = 0; e.pa = 0; e.cm = 0; e.upa = 0; e.st = 0;
        e.mask = 32'hFFFF_FFFF; e.req = req;
        put(e, a, s, w);
    endtask

    task automatic lk_pass(logic [31:0] a, string req);
        exp_t e;
        e.hit = 1; e.pa = a; e.cm = 0; e.upa = 0;
        e.st = {a[31:12], 12'h003};
        e.mask = 32'hFFFF_FFFF; e.req = req;
        put(e, a, 0, 0);
    endtask

    task automatic fill(logic [31:0] a, logic s, logic [31:0] d);
        fill_valid = 1; fill_addr = a; fill_super = s; fill_desc = d;
    endtask

    task automatic flush(logic [1:0] k, logic [31:0] a);
        flush_valid = 1; flush_kind = k; flush_addr = a;
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL R14: %0d responses missing, expected 0", exp_q.size());
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run hung, actual running expected done");
            finish_run();
        end
    end

    logic [31:0] dA, dB, dB2, dC, dD, dE;

    initial begin
        rst = 1; xlat_ctrl = CTL_4K;
        lk_valid = 0; lk_addr = 0; lk_super = 0; lk_write = 0;
        fill_valid = 0; fill_addr = 0; fill_super = 0; fill_desc = 0;
        flush_valid = 0; flush_kind = 0; flush_addr = 0;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1: rsp_valid actual %b expected 0", rsp_valid);
        end

        lk_miss(32'h1234_5678, 0, 0, "R1 empty after reset"); tick();

        // R2 pass-through
        xlat_ctrl = CTL_OFF;
        lk_pass(32'hDEAD_BEEF, "R2 disabled passthrough"); tick();
        lk_pass(32'h0040_3ABC, "R2 disabled passthrough 2"); tick();
        xlat_ctrl = CTL_4K;

        dA = mkd(20'hABCDE, 0, 2'b10, 0, 2'b01, 1, 0, 2'b01);
        fill(32'h0040_3000, 0, dA); tick();
        lk_hit(32'h0040_3ABC, 0, 0, dA, 0, "R6 R7 hit fields"); tick();
        lk_miss(32'h0040_2ABC, 0, 0, "R3 4K tag includes bit 12"); tick();
        lk_miss(32'h0040_3ABC, 1, 0, "R4 supervisor space separate"); tick();
        xlat_ctrl = CTL_8K;
        lk_hit(32'h0040_2ABC, 0, 0, dA, 1, "R3 8K tag ignores bit 12"); tick();
        xlat_ctrl = CTL_4K;

        dB = mkd(20'h12345, 1, 2'b01, 1, 2'b10, 0, 1, 2'b11);
        fill(32'h0080_0000, 1, dB); tick();
        lk_hit(32'h0080_0F00, 1, 0, dB, 0, "R6 R7 read of unmodified"); tick();
        lk_miss(32'h0080_0F00, 1, 1, "R5 write to unmodified misses"); tick();
        dB2 = mkd(20'h12345, 1, 2'b01, 1, 2'b10, 1, 1, 2'b11);
        fill(32'h0080_0000, 1, dB2); tick();
        lk_hit(32'h0080_0F04, 1, 1, dB2, 0, "R5 R12 write after refill"); tick();

        dC = mkd(20'h0C0C0, 0, 2'b00, 0, 2'b11, 1, 0, 2'b01);
        dD = mkd(20'h0D0D0, 1, 2'b11, 0, 2'b00, 1, 0, 2'b01);
        fill(32'h0100_0000, 0, dC); tick();
        fill(32'h0200_0000, 0, dD); tick();
        dE = mkd(20'h0E0E0, 0, 2'b01, 0, 2'b01, 1, 0, 2'b01);
        fill(32'h0300_0000, 0, dE); tick();
        lk_miss(32'h0040_3000, 0, 0, "R11 oldest slot replaced"); tick();
        lk_hit(32'h0300_0010, 0, 0, dE, 0, "R11 new entry present"); tick();
        lk_hit(32'h0100_0020, 0, 0, dC, 0, "R12 refill did not advance pointer"); tick();
        lk_hit(32'h0080_0030, 1, 0, dB2, 0, "R12 refilled entry kept"); tick();

        fill(32'h0400_0000, 0, mkd(20'h44444, 0, 0, 0, 0, 1, 0, 2'b00)); tick();
        fill(32'h0500_0000, 0, mkd(20'h55555, 0, 0, 0, 0, 1, 0, 2'b10)); tick();
        lk_miss(32'h0400_0000, 0, 0, "R13 invalid descriptor ignored"); tick();
        lk_miss(32'h0500_0000, 0, 0, "R13 indirect descriptor ignored"); tick();
        lk_hit(32'h0100_0000, 0, 0, dC, 0, "R13 no slot consumed"); tick();

        flush(2'b11, 32'h0080_0123); tick();
        lk_hit(32'h0080_0000, 1, 0, dB2, 0, "R10 page non-global spares global"); tick();
        flush(2'b11, 32'h0100_0456); tick();
        lk_miss(32'h0100_0000, 0, 0, "R10 page non-global removes"); tick();
        flush(2'b10, 32'h0200_0789); tick();
        lk_miss(32'h0200_0000, 0, 0, "R10 page flush removes global"); tick();
        lk_hit(32'h0300_0000, 0, 0, dE, 0, "R10 other pages untouched"); tick();

        flush(2'b01, 0);
        lk_hit(32'h0300_0000, 0, 0, dE, 0, "R8 same-cycle lookup sees old state"); tick();
        lk_miss(32'h0300_0000, 0, 0, "R9 non-global removed"); tick();
        lk_hit(32'h0080_0000, 1, 0, dB2, 0, "R9 global survives"); tick();

        flush(2'b00, 0);
        lk_hit(32'h0080_0000, 1, 0, dB2, 0, "R8 same-cycle lookup before flush-all"); tick();
        lk_miss(32'h0080_0000, 1, 0, "R8 flush-all empties"); tick();

        tick();
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R14: rsp_valid actual %b expected 0 when idle", rsp_valid);
        end
        tick();
        finish_run();
    end

endmodule